// File: doc/BRIEF.md
# Triggered Waveform Buffer with Charge-Sum Readout

This block keeps a running history of 10-bit samples from a single drift-chamber readout channel in a circular sample ring, writing one sample on every clock. When a trigger arrives, it looks back a programmable number of samples and takes a programmable window of consecutive samples from that point. In waveform mode every sample of the window goes out as its own word. In charge mode the window is summed into one charge value, which is sent together with the hit time presented on the trigger.

Each record is a header word followed by its payload words. The words are queued in an output FIFO that an external link drains through a valid/ready pair. Look-back, window length and mode are held in a small register file. The same register file reports a sticky flag for triggers refused while busy and a count of records dropped for lack of FIFO room.

Top module: `trig_wave_buf`

## Requirements
- R1: A trigger sampled at clock edge T, with look-back L and window N, selects the samples stored at edges T-L through T-L+N-1. Sample capture continues without pause while the window is read.
- R2: In waveform mode (mode 0), the header is followed by N words. Each has tag bits [17:16]=00 and carries one window sample, zero-extended, in window order.
- R3: In charge mode (mode 1), the header is followed by a time word and then a charge word. The time word has tag 10 and carries the hit_time value sampled with the trigger. The charge word has tag 11 and carries the exact sum of the N window samples, which cannot wrap, even with N=32 samples of 1023.
- R4: The header word has tag 01. Payload bit 8 holds the record's mode and bits [7:0] hold the trigger count, which counts accepted triggers from 0 after reset.
- R5: A trigger that arrives while a record is still being built is ignored and produces no words. It sets the sticky flag in status bit 0, which stays set until status is written.
- R6: If, when a trigger is accepted, the FIFO lacks room for the whole record (3 words in charge mode, N+1 in waveform mode), the record is dropped. The drop count in status bits [15:8] increments and saturates, and the trigger count still advances.
- R7: out_valid is high exactly while the FIFO holds a word. The head word stays stable until it is taken with out_ready, and words leave in the order they were written.
- R8: The register file uses these addresses: 0 for look-back, 1 for window, 2 for mode (bit 0), and 3 for status. Reset values are 160, 16, 0 and 0. Writes clamp look-back to 1..255 and window to 1..32, and any write to address 3 clears both status fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample is captured per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 10 | ADC sample for the current clock |
| trig | input | 1 | Trigger request, sampled each clock |
| hit_time | input | 16 | Hit time from the timing discriminator, captured with the trigger |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_addr (combinational) |
| out_data | output | 18 | FIFO head word: tag in [17:16], payload in [15:0] |
| out_valid | output | 1 | FIFO holds at least one word |
| out_ready | input | 1 | Consumer takes the head word on this clock |

## Verification
The assertions do not assume any particular trigger spacing or out_ready pattern. They do assume that the FIFO is at least one word deeper than the largest window, so the admission check is the only thing that keeps the FIFO from overflowing.

The bench lets the ring fill past the largest look-back before the first trigger. In the sweeps it drains each record completely before firing again, and it only withholds out_ready in the drop scenario. Because of this, every refused trigger and every dropped record is one the bench caused on purpose.

// File: rtl/trig_wave_buf.sv
module trig_wave_buf #(
  parameter int SMP_W      = 10,
  parameter int RING_DEPTH = 256,
  parameter int WIN_MAX    = 32,
  parameter int TDC_W      = 16,
  parameter int TRG_W      = 8,
  parameter int FIFO_DEPTH = 64,
  parameter int LAT_RST    = 160,
  parameter int WIN_RST    = 16,
  localparam int RA_W  = $clog2(RING_DEPTH),
  localparam int WL_W  = $clog2(WIN_MAX + 1),
  localparam int QW    = SMP_W + WL_W,
  localparam int PW0   = (QW > TDC_W) ? QW : TDC_W,
  localparam int PW1   = (PW0 > TRG_W + 1) ? PW0 : TRG_W + 1,
  localparam int PAY_W = (PW1 > SMP_W) ? PW1 : SMP_W,
  localparam int OUT_W = PAY_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_in,
  input  logic             trig,
  input  logic [TDC_W-1:0] hit_time,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  output logic [OUT_W-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int FA_W = $clog2(FIFO_DEPTH);
  localparam int FC_W = $clog2(FIFO_DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_TIME, S_CHG} st_e;
  st_e st;

  logic [SMP_W-1:0] ring [RING_DEPTH];
  logic [RA_W-1:0]  wp, rp, rp_go;
  logic [SMP_W-1:0] smp_rd;

  logic [RA_W-1:0]  lat_r;
  logic [WL_W-1:0]  win_r;
  logic             mode_r, ovf_r;
  logic [7:0]       drop_r;
  logic [TRG_W-1:0] trg_cnt;

  logic             cur_mode;
  logic [WL_W-1:0]  rd_left;
  logic [TDC_W-1:0] t_lat;
  logic [QW-1:0]    acc;

  logic [OUT_W-1:0] fmem [FIFO_DEPTH];
  logic [FA_W-1:0]  fwp, frp;
  logic [FC_W-1:0]  fcnt;
  logic [FC_W:0]    need, room;
  logic             push, pop, busy, accept, fits, go, st_clr, rd_phase;
  logic [OUT_W-1:0] pword;

  assign busy     = (st != S_IDLE);
  assign rd_phase = (st == S_READ);
  assign accept   = trig && !busy;
  assign need     = mode_r ? (FC_W+1)'(3) : (FC_W+1)'(win_r) + 1'b1;
  assign room     = (FC_W+1)'(FIFO_DEPTH) - (FC_W+1)'(fcnt);
  assign fits     = (need <= room);
  assign go       = accept && fits;
  assign st_clr   = cfg_we && (cfg_addr == 2'd3);
  assign smp_rd   = ring[rp];
  assign rp_go    = (wp >= lat_r) ? wp - lat_r
                                  : RA_W'(32'(wp) + RING_DEPTH - 32'(lat_r));

  always_ff @(posedge clk) ring[wp] <= smp_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wp <= '0;
    else        wp <= (wp == RA_W'(RING_DEPTH - 1)) ? '0 : wp + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_r  <= RA_W'(LAT_RST);
      win_r  <= WL_W'(WIN_RST);
      mode_r <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: if (cfg_wdata == 16'd0)                    lat_r <= RA_W'(1);
              else if (32'(cfg_wdata) > RING_DEPTH - 1)  lat_r <= RA_W'(RING_DEPTH - 1);
              else                                       lat_r <= RA_W'(cfg_wdata);
        2'd1: if (cfg_wdata == 16'd0)                    win_r <= WL_W'(1);
              else if (32'(cfg_wdata) > WIN_MAX)         win_r <= WL_W'(WIN_MAX);
              else                                       win_r <= WL_W'(cfg_wdata);
        2'd2: mode_r <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb
    case (cfg_addr)
      2'd0:    cfg_rdata = 16'(lat_r);
      2'd1:    cfg_rdata = 16'(win_r);
      2'd2:    cfg_rdata = {15'd0, mode_r};
      default: cfg_rdata = {drop_r, 7'd0, ovf_r};
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_r   <= 1'b0;
      drop_r  <= '0;
      trg_cnt <= '0;
    end else begin
      if (trig && busy)          ovf_r <= 1'b1;
      else if (st_clr)           ovf_r <= 1'b0;
      if (accept && !fits)       drop_r <= (drop_r == 8'hFF) ? drop_r : drop_r + 1'b1;
      else if (st_clr)           drop_r <= '0;
      if (accept)                trg_cnt <= trg_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rp       <= '0;
      rd_left  <= '0;
      cur_mode <= 1'b0;
      t_lat    <= '0;
      acc      <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st       <= S_READ;
          rp       <= rp_go;
          rd_left  <= win_r;
          cur_mode <= mode_r;
          t_lat    <= hit_time;
          acc      <= '0;
        end
        S_READ: begin
          acc     <= acc + QW'(smp_rd);
          rp      <= (rp == RA_W'(RING_DEPTH - 1)) ? '0 : rp + 1'b1;
          rd_left <= rd_left - 1'b1;
          if (rd_left == WL_W'(1)) st <= cur_mode ? S_TIME : S_IDLE;
        end
        S_TIME:  st <= S_CHG;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    push  = 1'b0;
    pword = '0;
    if (go) begin
      push  = 1'b1;
      pword = {2'b01, PAY_W'({mode_r, trg_cnt})};
    end else begin
      case (st)
        S_READ: if (!cur_mode) begin
          push  = 1'b1;
          pword = {2'b00, PAY_W'(smp_rd)};
        end
        S_TIME: begin
          push  = 1'b1;
          pword = {2'b10, PAY_W'(t_lat)};
        end
        S_CHG: begin
          push  = 1'b1;
          pword = {2'b11, PAY_W'(acc)};
        end
        default: ;
      endcase
    end
  end

  assign out_valid = (fcnt != '0);
  assign out_data  = fmem[frp];
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) if (push) fmem[fwp] <= pword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwp  <= '0;
      frp  <= '0;
      fcnt <= '0;
    end else begin
      if (push) fwp <= (fwp == FA_W'(FIFO_DEPTH - 1)) ? '0 : fwp + 1'b1;
      if (pop)  frp <= (frp == FA_W'(FIFO_DEPTH - 1)) ? '0 : frp + 1'b1;
      case ({push, pop})
        2'b10:   fcnt <= fcnt + 1'b1;
        2'b01:   fcnt <= fcnt - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trig_wave_buf_chk.sv
module trig_wave_buf_chk #(
  parameter int OUT_W      = 18,
  parameter int QW         = 16,
  parameter int FC_W       = 7,
  parameter int FIFO_DEPTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig,
  input logic             busy,
  input logic             rd_phase,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic             ovf_r,
  input logic [7:0]       drop_r,
  input logic [QW-1:0]    acc,
  input logic [FC_W-1:0]  fcnt,
  input logic [OUT_W-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready
);
  a_r5_busy_trig_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trig) |=> ovf_r);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_r && !(cfg_we && cfg_addr == 2'd3)) |=> ovf_r);

  a_r6_drop_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == 2'd3) |=> (drop_r >= $past(drop_r)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_phase |=> (acc >= $past(acc)));

  a_r7_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r7_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(fcnt) <= FIFO_DEPTH));
endmodule

bind trig_wave_buf trig_wave_buf_chk #(
  .OUT_W(OUT_W), .QW(QW), .FC_W(FC_W), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy), .rd_phase(rd_phase),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .ovf_r(ovf_r), .drop_r(drop_r),
  .acc(acc), .fcnt(fcnt), .out_data(out_data), .out_valid(out_valid),
  .out_ready(out_ready)
);

// File: tb/trig_wave_buf_tb.sv
module trig_wave_buf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  smp_in = '0;
  logic        trig = 1'b0;
  logic [15:0] hit_time = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [17:0] out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  int exp_cnt = 0;
  bit flat = 1'b0;

  trig_wave_buf u_dut (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .trig(trig), .hit_time(hit_time),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int smp(int e);
    return flat ? 1023 : ((e * 37 + 11) % 1024);
  endfunction

  always @(negedge clk) smp_in <= 10'(smp(cyc));

  always @(posedge clk)
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk);
    cfg_addr = 2'(a);
    #2 d = int'(cfg_rdata);
  endtask

  task automatic fire(int hit, output int kt);
    @(negedge clk);
    trig = 1'b1; hit_time = 16'(hit); kt = cyc;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic get_word(output logic [17:0] w);
    w = '1;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (out_valid) begin
        w = out_data;
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
        return;
      end
    end
  endtask

  task automatic check_rec(int mode, int n, int l, int kt, int hit, int cnt);
    logic [17:0] w;
    longint exp;
    int sum = 0;
    get_word(w);
    exp = {2'b01, 16'(mode * 256 + (cnt % 256))};
    check(w == 18'(exp), "R4 header", w, exp);
    if (mode == 0) begin
      for (int j = 0; j < n; j++) begin
        get_word(w);
        exp = {2'b00, 16'(smp(kt - l + j))};
        check(w == 18'(exp), "R1/R2 sample", w, exp);
      end
    end else begin
      for (int j = 0; j < n; j++) sum += smp(kt - l + j);
      get_word(w);
      exp = {2'b10, 16'(hit)};
      check(w == 18'(exp), "R3 time", w, exp);
      get_word(w);
      exp = {2'b11, 16'(sum)};
      check(w == 18'(exp), "R1/R3 charge", w, exp);
    end
  endtask

  initial begin
    int d, kt, ka, kc;
    int wins[4] = '{1, 3, 16, 32};
    int lats[4] = '{1, 7, 160, 255};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(0, d); check(d == 160, "R8 reset look-back", d, 160);
    rd(1, d); check(d == 16,  "R8 reset window", d, 16);
    rd(2, d); check(d == 0,   "R8 reset mode", d, 0);
    rd(3, d); check(d == 0,   "R8 reset status", d, 0);
    check(out_valid == 1'b0, "R7 empty after reset", out_valid, 0);

    wr(1, 0);   rd(1, d); check(d == 1,   "R8 window clamp low", d, 1);
    wr(1, 40);  rd(1, d); check(d == 32,  "R8 window clamp high", d, 32);
    wr(0, 0);   rd(0, d); check(d == 1,   "R8 look-back clamp low", d, 1);
    wr(0, 300); rd(0, d); check(d == 255, "R8 look-back clamp high", d, 255);
    wr(2, 3);   rd(2, d); check(d == 1,   "R8 mode bit", d, 1);

    repeat (300) @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 4; i++)
        for (int k = 0; k < 4; k++) begin
          wr(2, m); wr(1, wins[i]); wr(0, lats[k]);
          fire(1000 + 17 * (m * 16 + i * 4 + k), kt);
          check_rec(m, wins[i], lats[k], kt, 1000 + 17 * (m * 16 + i * 4 + k), exp_cnt);
          exp_cnt++;
        end

    flat = 1'b1;
    wr(2, 1); wr(1, 32); wr(0, 200);
    repeat (300) @(negedge clk);
    fire(16'hBEEF, kt);
    check_rec(1, 32, 200, kt, 16'hBEEF, exp_cnt);
    exp_cnt++;
    flat = 1'b0;
    repeat (300) @(negedge clk);

    wr(2, 0); wr(1, 16); wr(0, 50);
    fire(5, kt);
    repeat (2) @(negedge clk);
    fire(6, ka);
    repeat (30) @(negedge clk);
    rd(3, d); check(d == 1, "R5 refused trigger flag", d, 1);
    check_rec(0, 16, 50, kt, 5, exp_cnt);
    exp_cnt++;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R5 refused trigger made no words", out_valid, 0);
    rd(3, d); check(d == 1, "R5 flag sticky", d, 1);
    wr(3, 0); rd(3, d); check(d == 0, "R5 flag cleared", d, 0);

    wr(1, 32); wr(0, 40);
    fire(7, ka);
    repeat (40) @(negedge clk);
    fire(8, kt);
    repeat (40) @(negedge clk);
    rd(3, d); check(d == 16'h0100, "R6 drop count", d, 16'h0100);
    wr(2, 1);
    fire(9, kc);
    repeat (10) @(negedge clk);
    check_rec(0, 32, 40, ka, 7, exp_cnt);
    check_rec(1, 32, 40, kc, 9, exp_cnt + 2);
    exp_cnt += 3;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R6 dropped record made no words", out_valid, 0);
    wr(3, 0); rd(3, d); check(d == 0, "R6 drop count cleared", d, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule